// File: doc/BRIEF.md
# Interrupt Controller Error Status Logic

This block watches the traffic around a local interrupt controller and records the errors it finds in a small error status register. It inspects the vector of every outgoing command write and every self-interrupt write. It also inspects every incoming interrupt message, whether that message came from another controller, from a local vector table entry or from a looped-back self-interrupt. A vector of 0x0F or below is illegal. An incoming interrupt with an illegal vector is dropped: nothing is delivered and no request bit is set. Outgoing commands with illegal vectors are not issued.

Register accesses arrive on a simple one-cycle request port. Only accesses inside a 4 KB window at a static base address are considered. In legacy mode, touching a reserved 16-byte slot is logged as an error. In extended mode, that access raises a one-cycle fault pulse and has no other effect. A non-zero write to the status register, or a write that sets reserved bits, also raises the fault pulse. Errors collect in a hidden pending register. A status-register write publishes the pending bits and clears them. A one-cycle error interrupt request fires whenever an error bit becomes newly pending.

Top module: `intc_err_status`

## Requirements
- R1: A vector is illegal when it is 0x0F or lower. An incoming interrupt with a legal vector gives, on the next cycle, `deliver_valid`=1, `deliver_vec` equal to that vector and `irr_set` with only bit `vector` high. An illegal one gives no delivery, `irr_set`=0 and sets pending bit 6.
- R2: A write to the command slot (offset 0x300) in either mode issues, on the next cycle, `cmd_valid`=1, `cmd_vec`=wdata[7:0] and `cmd_self`=0 when the vector is legal. An illegal vector issues nothing and sets pending bit 5. An incoming interrupt in the same cycle is handled independently.
- R3: In extended mode, a write to the self-interrupt slot (offset 0x3F0) behaves like R2 but with `cmd_self`=1. In legacy mode that slot is reserved.
- R4: In legacy mode, a read or write of any slot other than the status slot (0x280) and the command slot sets pending bit 7 and never raises `fault`.
- R5: In extended mode, a read or write of a reserved slot pulses `fault` for exactly one cycle and logs no error.
- R6: In extended mode, a non-zero write to the status slot pulses `fault` and neither publishes nor clears the pending bits.
- R7: In extended mode, a command write with any of wdata[31:20] set, or a self-interrupt write with any of wdata[31:8] set, pulses `fault` and issues and logs nothing. In legacy mode those bits are ignored.
- R8: A read of the status slot returns the published bits at positions 5 (send vector), 6 (receive vector) and 7 (register address), all other bits zero. A status write that does not fault (any value in legacy mode, zero in extended mode) copies pending to published and clears pending. Errors detected in that same cycle remain pending.
- R9: `err_irq` pulses for one cycle after an edge at which some error bit was newly added to pending, unless `err_mask` was high. A bit that is already pending raises no request.
- R10: A register access outside the window has no effect, and `reg_rdata` reads zero.
- R11: After reset all outputs are low and both pending and published status are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_mode | input | 1 | 1 selects extended mode, 0 legacy mode |
| win_base | input | ADDR_W | Base of the 4 KB register window (low 12 bits unused) |
| err_mask | input | 1 | Masks the error interrupt request |
| reg_req | input | 1 | Register access this cycle |
| reg_wr | input | 1 | 1 write, 0 read |
| reg_addr | input | ADDR_W | Byte address of the access |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, same cycle |
| fault | output | 1 | One-cycle fault pulse (extended mode) |
| irq_in_valid | input | 1 | Incoming interrupt message present |
| irq_in_vec | input | VEC_W | Vector of the incoming interrupt |
| deliver_valid | output | 1 | Interrupt delivered to the processor |
| deliver_vec | output | VEC_W | Delivered vector, zero when idle |
| irr_set | output | 2**VEC_W | One-hot request-bit set strobe |
| cmd_valid | output | 1 | Outgoing interrupt command issued |
| cmd_vec | output | VEC_W | Vector of the issued command, zero when idle |
| cmd_self | output | 1 | Issued command targets this controller |
| err_irq | output | 1 | One-cycle error interrupt request |

## Verification
The bench uses the default parameters: 8-bit vectors with the illegal limit at 0x0F, a 32-bit data path, and a 20-bit command field and an 8-bit self field. With these values the boundary between vectors 0x0F and 0x10 can be tested directly. A 256-wide request strobe can be checked one-hot. The reserved command bits and self-interrupt bits can be set one at a time at bit 25 and bit 8. The 4 KB window lets the bench aim at the same slot offsets one page higher to show that out-of-window accesses are ignored.

// File: rtl/intc_err_status.sv
module intc_err_status #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int VEC_W = 8,
  parameter int VEC_ILLEGAL_MAX = 15,
  parameter logic [7:0] ESR_SLOT = 8'h28,
  parameter logic [7:0] ICR_SLOT = 8'h30,
  parameter logic [7:0] SELF_SLOT = 8'h3F,
  parameter int ICR_FIELD_W = 20,
  parameter int SELF_FIELD_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ext_mode,
  input  logic [ADDR_W-1:0]     win_base,
  input  logic                  err_mask,
  input  logic                  reg_req,
  input  logic                  reg_wr,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  output logic                  fault,
  input  logic                  irq_in_valid,
  input  logic [VEC_W-1:0]      irq_in_vec,
  output logic                  deliver_valid,
  output logic [VEC_W-1:0]      deliver_vec,
  output logic [(1<<VEC_W)-1:0] irr_set,
  output logic                  cmd_valid,
  output logic [VEC_W-1:0]      cmd_vec,
  output logic                  cmd_self,
  output logic                  err_irq
);
  localparam int PAGE_LSB = 12;
  localparam int SLOT_LSB = 4;
  localparam int NVEC = 1 << VEC_W;
  localparam int ST_LSB = 5;
  localparam int ST_W = 3;
  localparam logic [VEC_W-1:0] VMAX = VEC_W'(VEC_ILLEGAL_MAX);

  logic [ST_W-1:0] pend, esr, new_err;
  logic [PAGE_LSB-SLOT_LSB-1:0] slot;
  logic hit, is_esr, is_icr, is_self, rsvd_slot, icr_rsvd, self_rsvd;
  logic flt_now, send_wr, esr_clr, vec_bad, in_bad;

  assign hit       = reg_req && (reg_addr[ADDR_W-1:PAGE_LSB] == win_base[ADDR_W-1:PAGE_LSB]);
  assign slot      = reg_addr[PAGE_LSB-1:SLOT_LSB];
  assign is_esr    = slot == ESR_SLOT;
  assign is_icr    = slot == ICR_SLOT;
  assign is_self   = ext_mode && slot == SELF_SLOT;
  assign rsvd_slot = !(is_esr || is_icr || is_self);
  assign icr_rsvd  = |reg_wdata[DATA_W-1:ICR_FIELD_W];
  assign self_rsvd = |reg_wdata[DATA_W-1:SELF_FIELD_W];
  assign vec_bad   = reg_wdata[VEC_W-1:0] <= VMAX;
  assign in_bad    = irq_in_vec <= VMAX;

  assign flt_now = hit && ext_mode &&
                   (rsvd_slot ||
                    (reg_wr && is_esr && |reg_wdata) ||
                    (reg_wr && is_icr && icr_rsvd) ||
                    (reg_wr && is_self && self_rsvd));
  assign send_wr = hit && reg_wr && !flt_now && (is_icr || is_self);
  assign esr_clr = hit && reg_wr && is_esr && !flt_now;

  assign new_err[0] = send_wr && vec_bad;
  assign new_err[1] = irq_in_valid && in_bad;
  assign new_err[2] = hit && !ext_mode && rsvd_slot;

  assign reg_rdata = (hit && !reg_wr && is_esr)
                   ? {{(DATA_W-ST_LSB-ST_W){1'b0}}, esr, {ST_LSB{1'b0}}} : '0;
  assign irr_set   = deliver_valid ? ({{(NVEC-1){1'b0}}, 1'b1} << deliver_vec) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend          <= '0;
      esr           <= '0;
      fault         <= 1'b0;
      err_irq       <= 1'b0;
      deliver_valid <= 1'b0;
      deliver_vec   <= '0;
      cmd_valid     <= 1'b0;
      cmd_vec       <= '0;
      cmd_self      <= 1'b0;
    end else begin
      fault         <= flt_now;
      err_irq       <= |(new_err & ~pend) && !err_mask;
      deliver_valid <= irq_in_valid && !in_bad;
      deliver_vec   <= (irq_in_valid && !in_bad) ? irq_in_vec : '0;
      cmd_valid     <= send_wr && !vec_bad;
      cmd_vec       <= (send_wr && !vec_bad) ? reg_wdata[VEC_W-1:0] : '0;
      cmd_self      <= send_wr && !vec_bad && is_self;
      if (esr_clr) begin
        esr  <= pend;
        pend <= new_err;
      end else begin
        pend <= pend | new_err;
      end
    end
  end

  a_r1_no_illegal_delivery: assert property (@(posedge clk) disable iff (!rst_n)
    deliver_valid |-> deliver_vec > VMAX);
  a_r2_no_illegal_command: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_vec > VMAX);
  a_r5_fault_only_extended: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> $past(ext_mode));
  a_r9_mask_blocks_request: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> !$past(err_mask));
  a_r8_publish_pending: assert property (@(posedge clk) disable iff (!rst_n)
    esr_clr |=> esr == $past(pend));
  a_r10_outside_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && !hit && !irq_in_valid) |=> !fault && !cmd_valid && !err_irq);
  a_r1_irr_matches_delivery: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(irr_set) == (deliver_valid ? 1 : 0));
endmodule

// File: tb/intc_err_status_test.sv
module intc_err_status_test;
  localparam logic [31:0] BASE = 32'hFEE0_0000;
  localparam logic [31:0] O_ESR = 32'h280, O_ICR = 32'h300, O_SELF = 32'h3F0;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic ext_mode = 0, err_mask = 0, reg_req = 0, reg_wr = 0, irq_in_valid = 0;
  logic [31:0] reg_addr = '0, reg_wdata = '0, reg_rdata;
  logic [7:0] irq_in_vec = '0, deliver_vec, cmd_vec;
  logic [255:0] irr_set;
  logic fault, deliver_valid, cmd_valid, cmd_self, err_irq;

  intc_err_status uut (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .win_base(BASE), .err_mask(err_mask),
    .reg_req(reg_req), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .fault(fault), .irq_in_valid(irq_in_valid), .irq_in_vec(irq_in_vec),
    .deliver_valid(deliver_valid), .deliver_vec(deliver_vec), .irr_set(irr_set),
    .cmd_valid(cmd_valid), .cmd_vec(cmd_vec), .cmd_self(cmd_self), .err_irq(err_irq));

  typedef struct packed {
    logic dv; logic [7:0] dvec; logic cv; logic [7:0] cvec; logic cs; logic flt; logic eirq;
  } obs_t;

  obs_t exp_q[$];
  string tag_q[$];
  int checks = 0, fails = 0;

  function automatic obs_t mk(logic dv, logic [7:0] dvec, logic cv, logic [7:0] cvec,
                              logic cs, logic flt, logic eirq);
    return {dv, dvec, cv, cvec, cs, flt, eirq};
  endfunction

  always @(posedge clk) begin
    obs_t e, a;
    string t;
    logic [255:0] ei;
    #2;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {deliver_valid, deliver_vec, cmd_valid, cmd_vec, cmd_self, fault, err_irq};
      ei = e.dv ? (256'(1) << e.dvec) : '0;
      checks++;
      if (a !== e || irr_set !== ei) begin
        fails++;
        $display("FAIL %s: outputs %h irr %h, expected %h irr %h", t, a, irr_set, e, ei);
      end
    end
  end

  task automatic cyc(input logic rq, input logic wr, input logic [31:0] addr,
                     input logic [31:0] wd, input logic iv, input logic [7:0] ivec,
                     input obs_t e, input string t, input logic chk, input logic [31:0] erd);
    @(negedge clk);
    reg_req = rq; reg_wr = wr; reg_addr = addr; reg_wdata = wd;
    irq_in_valid = iv; irq_in_vec = ivec;
    exp_q.push_back(e);
    tag_q.push_back(t);
    if (chk) begin
      #1;
      checks++;
      if (reg_rdata !== erd) begin
        fails++;
        $display("FAIL %s: rdata %h expected %h", t, reg_rdata, erd);
      end
    end
  endtask

  task automatic mode(input logic m, input logic k);
    @(negedge clk);
    ext_mode = m; err_mask = k; reg_req = 0; irq_in_valid = 0;
    exp_q.push_back('0);
    tag_q.push_back("mode change");
  endtask

  task automatic irq(input logic [7:0] v, input logic dv, input logic eirq, input string t);
    cyc(0, 0, '0, '0, 1, v, mk(dv, dv ? v : 8'h0, 0, 0, 0, 0, eirq), t, 0, '0);
  endtask

  task automatic wr(input logic [31:0] off, input logic [31:0] d, input logic cv,
                    input logic cs, input logic flt, input logic eirq, input string t);
    cyc(1, 1, BASE + off, d, 0, 0, mk(0, 0, cv, cv ? d[7:0] : 8'h0, cs, flt, eirq), t, 0, '0);
  endtask

  task automatic rd(input logic [31:0] off, input logic [31:0] erd, input logic flt,
                    input logic eirq, input string t);
    cyc(1, 0, BASE + off, '0, 0, 0, mk(0, 0, 0, 0, 0, flt, eirq), t, 1, erd);
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #3;
    checks++;
    if ({fault, deliver_valid, cmd_valid, err_irq, irr_set} !== '0) begin
      fails++;
      $display("FAIL R11: outputs nonzero in reset, expected 0");
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    mode(0, 0);
    rd(O_ESR, 32'h0, 0, 0, "R11 status zero after reset");

    irq(8'h40, 1, 0, "R1 legal vector delivered");
    irq(8'h0F, 0, 1, "R1 vector 0x0F dropped, R9 request");
    irq(8'h10, 1, 0, "R1 vector 0x10 delivered");
    rd(O_ESR, 32'h0, 0, 0, "R8 pending not yet published");
    wr(O_ESR, 32'h123, 0, 0, 0, 0, "R8 legacy publish write");
    rd(O_ESR, 32'h40, 0, 0, "R8 receive bit published");

    wr(O_ICR, 32'h05, 0, 0, 0, 1, "R2 illegal command vector");
    wr(O_ICR, 32'hFFF0_0030, 1, 0, 0, 0, "R2 legal command, R7 legacy ignores high bits");
    wr(O_SELF, 32'h50, 0, 0, 0, 1, "R3 self slot reserved in legacy, R4");
    rd(32'h100, 32'h0, 0, 0, "R4 reserved read, no fault, bit already pending");
    wr(O_ESR, 32'h0, 0, 0, 0, 0, "R8 publish");
    rd(O_ESR, 32'hA0, 0, 0, "R8 send and address bits");

    mode(0, 1);
    irq(8'h00, 0, 0, "R9 masked request");
    mode(0, 0);
    wr(O_ESR, 32'h0, 0, 0, 0, 0, "R9 publish");
    rd(O_ESR, 32'h40, 0, 0, "R9 error logged while masked");

    cyc(1, 1, BASE + 32'h1000 + O_ICR, 32'h03, 0, 0, '0, "R10 outside write ignored", 0, '0);
    cyc(1, 0, BASE + 32'h1000 + O_ESR, 32'h0, 0, 0, '0, "R10 outside read zero", 1, 32'h0);
    wr(O_ESR, 32'h0, 0, 0, 0, 0, "R10 publish");
    rd(O_ESR, 32'h0, 0, 0, "R10 nothing logged from outside access");

    cyc(1, 1, BASE + O_ICR, 32'h77, 1, 8'h88, mk(1, 8'h88, 1, 8'h77, 0, 0, 0),
        "R2 command and delivery together", 0, '0);

    mode(1, 0);
    rd(32'h100, 32'h0, 1, 0, "R5 reserved read faults");
    rd(O_ESR, 32'h0, 0, 0, "R5 fault lasts one cycle");
    wr(O_ESR, 32'h0, 0, 0, 0, 0, "R5 publish");
    rd(O_ESR, 32'h0, 0, 0, "R5 reserved access not logged");

    irq(8'h02, 0, 1, "R1 illegal vector in extended mode");
    wr(O_ESR, 32'h1, 0, 0, 1, 0, "R6 nonzero status write faults");
    rd(O_ESR, 32'h0, 0, 0, "R6 nothing published");
    wr(O_ESR, 32'h0, 0, 0, 0, 0, "R6 zero write publishes");
    rd(O_ESR, 32'h40, 0, 0, "R6 pending kept through fault");

    wr(O_ICR, 32'h0A, 0, 0, 0, 1, "R2 illegal command extended");
    wr(O_SELF, 32'h21, 1, 1, 0, 0, "R3 legal self interrupt");
    wr(O_SELF, 32'h0F, 0, 0, 0, 0, "R3 illegal self, bit already pending");
    rd(O_SELF, 32'h0, 0, 0, "R3 self slot legal in extended mode");
    wr(O_ESR, 32'h0, 0, 0, 0, 0, "R3 publish");
    rd(O_ESR, 32'h20, 0, 0, "R3 send bit published");

    wr(O_ICR, 32'h0200_0040, 0, 0, 1, 0, "R7 command reserved bit faults");
    wr(O_SELF, 32'h140, 0, 0, 1, 0, "R7 self reserved bit faults");
    wr(O_ESR, 32'h0, 0, 0, 0, 0, "R7 publish");
    rd(O_ESR, 32'h0, 0, 0, "R7 faulting writes not logged");

    mode(1, 0);
    mode(1, 0);
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule